// File: doc/BRIEF.md
# Trace Cache Lookup Array

This block holds recently built instruction traces and answers one fetch lookup per cycle. A trace is a run of up to 24 instructions, in the order they execute, covering no more than three basic blocks. It is filed under the program counter of its first instruction. Each entry carries a valid bit, an address tag, the number of branches inside the trace, a direction bit for every branch except the last, the instruction count, a taken-target address and a fall-through address.

A lookup supplies a PC and one predicted direction per branch slot. An entry hits only when its tag matches and the predictions for all of its branches except the last agree with the stored direction bits. The last branch's prediction then chooses between the target and the fall-through address as the next fetch PC. The array is two-way set associative, so two traces that start at the same instruction but follow different paths can both be held. A fill port writes finished traces. It overwrites an entry that describes the same path, takes an empty way next, and otherwise evicts the least recently used way.

Top module: `trace_cache_array`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses until a fill has been written, and `rsp_valid` is low while no lookup has been made.
- R2: A lookup presented with `lk_valid` high in one cycle gives `rsp_valid` high in the next cycle. `rsp_valid` is low in the cycle after any cycle without a lookup.
- R3: The set index is `pc[IDX_W+1:2]` and the tag is the bits above it. `pc[1:0]` has no effect. A different tag in the same set misses.
- R4: For an entry with `nbr` branches, prediction bit i (with i < nbr-1) must equal stored direction bit i for a hit. Prediction bits at or above nbr-1 do not affect the hit.
- R5: On a hit, `rsp_next_pc` is the fall-through address when `nbr` is 0. Otherwise it is the target address if prediction bit nbr-1 is 1, and the fall-through address if that bit is 0.
- R6: On a hit, `rsp_cnt` and `rsp_instrs` are the stored count and instructions. On a miss, `rsp_cnt`, `rsp_next_pc` and `rsp_instrs` are all zero.
- R7: Two fills with the same start PC but different direction bits occupy both ways of the set, and each is returned by the predictions that match it.
- R8: A fill whose tag, branch count and checked direction bits equal those of a valid entry in its set overwrites that entry. The other way is left intact.
- R9: Otherwise a fill goes to the lowest-numbered empty way. If both ways are valid, it evicts the least recently used way. Both lookup hits and fills mark a way as most recently used, and a fill takes precedence when both touch the same set in one cycle.
- R10: A lookup made in the same cycle as a fill to the same set sees the contents from before that fill.
- R11: When both ways of a set hit, way 0 supplies the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | PC_W | Fetch PC for the lookup |
| lk_pred | input | MAX_BR | Predicted direction per branch slot, 1 = taken |
| fill_en | input | 1 | Write a completed trace |
| fill_pc | input | PC_W | Start PC of the trace |
| fill_nbr | input | NBR_W | Branches in the trace |
| fill_dirs | input | MAX_BR-1 | Directions of all branches but the last |
| fill_cnt | input | CNT_W | Valid instructions in the trace |
| fill_target | input | PC_W | Next PC if the last branch is taken |
| fill_fallthru | input | PC_W | Next PC otherwise |
| fill_instrs | input | MAX_INSTR*INSTR_W | Instructions, slot k in bits k*INSTR_W upward |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Lookup hit |
| rsp_cnt | output | CNT_W | Instruction count, 0 on miss |
| rsp_next_pc | output | PC_W | Next fetch PC, 0 on miss |
| rsp_instrs | output | MAX_INSTR*INSTR_W | Trace instructions, 0 on miss |

## Verification
The hardest condition to reach from the ports is a full set holding two traces from the same start PC, where a fill has to decide between overwriting a matching path and evicting by recency, while the previous lookup hit has just changed which way is least recent. The stimulus reaches it in two ways. Directed sequences fill a set twice, hit one way and then fill a third path. A random phase draws tags from a pool of three per set, which keeps sets contended, and mixes in lookups and fills to the same set in the same cycle. A reference model in the bench tracks every entry and the recency bit of every set.

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the trace cache array.
// Assumes a fixed associativity of two; recency is then a single bit per set.
package tc_pkg;
    localparam int TC_WAYS = 2;
    typedef logic tc_way_t;
endpackage

// File: rtl/tc_way_store.sv
`timescale 1ns/1ps
// One way of the trace array: a valid bit per set plus the payload of each trace.
// Has one write port and two read ports: one for the lookup index, one for the
// fill index (used to find a matching path). Payload is not reset; only valid is.
module tc_way_store #(
    parameter int SETS   = 8,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 27,
    parameter int NBR_W  = 2,
    parameter int FLAG_W = 2,
    parameter int CNT_W  = 5,
    parameter int PC_W   = 32,
    parameter int DATA_W = 768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [NBR_W-1:0]  wr_nbr,
    input  logic [FLAG_W-1:0] wr_flags,
    input  logic [CNT_W-1:0]  wr_cnt,
    input  logic [PC_W-1:0]   wr_tgt,
    input  logic [PC_W-1:0]   wr_fall,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_vld,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [NBR_W-1:0]  rd_nbr,
    output logic [FLAG_W-1:0] rd_flags,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic [PC_W-1:0]   rd_tgt,
    output logic [PC_W-1:0]   rd_fall,
    output logic [DATA_W-1:0] rd_data,
    output logic              wq_vld,
    output logic [TAG_W-1:0]  wq_tag,
    output logic [NBR_W-1:0]  wq_nbr,
    output logic [FLAG_W-1:0] wq_flags
);
    logic [SETS-1:0]   vld_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [NBR_W-1:0]  nbr_q  [SETS];
    logic [FLAG_W-1:0] flg_q  [SETS];
    logic [CNT_W-1:0]  cnt_q  [SETS];
    logic [PC_W-1:0]   tgt_q  [SETS];
    logic [PC_W-1:0]   fall_q [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    // Valid bits: cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= '0;
        else if (wr_en)
            vld_q[wr_idx] <= 1'b1;
    end

    // Payload capture on a fill.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            nbr_q[wr_idx]  <= wr_nbr;
            flg_q[wr_idx]  <= wr_flags;
            cnt_q[wr_idx]  <= wr_cnt;
            tgt_q[wr_idx]  <= wr_tgt;
            fall_q[wr_idx] <= wr_fall;
            data_q[wr_idx] <= wr_data;
        end
    end

    // Lookup-side read.
    assign rd_vld   = vld_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_nbr   = nbr_q[rd_idx];
    assign rd_flags = flg_q[rd_idx];
    assign rd_cnt   = cnt_q[rd_idx];
    assign rd_tgt   = tgt_q[rd_idx];
    assign rd_fall  = fall_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

    // Fill-side read for path matching.
    assign wq_vld   = vld_q[wr_idx];
    assign wq_tag   = tag_q[wr_idx];
    assign wq_nbr   = nbr_q[wr_idx];
    assign wq_flags = flg_q[wr_idx];

    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_idx)]); // R9
endmodule

// File: rtl/tc_match.sv
`timescale 1ns/1ps
// Path comparator for one entry. Matches when the entry is valid, the tag is
// equal, and every direction bit below nbr-1 equals the query bit. With
// chk_nbr set the branch counts must also be equal (fill-side path identity).
module tc_match #(
    parameter int TAG_W  = 27,
    parameter int NBR_W  = 2,
    parameter int FLAG_W = 2
) (
    input  logic              e_vld,
    input  logic [TAG_W-1:0]  e_tag,
    input  logic [NBR_W-1:0]  e_nbr,
    input  logic [FLAG_W-1:0] e_flags,
    input  logic [TAG_W-1:0]  q_tag,
    input  logic [NBR_W-1:0]  q_nbr,
    input  logic [FLAG_W-1:0] q_flags,
    input  logic              chk_nbr,
    output logic              match
);
    logic dirs_ok;

    // Compare only the direction bits the entry actually records.
    always_comb begin
        dirs_ok = 1'b1;
        for (int i = 0; i < FLAG_W; i++)
            if ((i + 1) < int'(e_nbr) && e_flags[i] != q_flags[i])
                dirs_ok = 1'b0;
        match = e_vld && (e_tag == q_tag) && (!chk_nbr || e_nbr == q_nbr) && dirs_ok;
    end
endmodule

// File: rtl/tc_lru.sv
`timescale 1ns/1ps
// Recency state of a two-way array: one bit per set naming the least recently
// used way. A fill takes precedence over a lookup hit in the same set.
module tc_lru #(
    parameter int SETS  = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_en,
    input  logic [IDX_W-1:0] hit_idx,
    input  tc_pkg::tc_way_t  hit_way,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tc_pkg::tc_way_t  wr_way,
    input  logic [IDX_W-1:0] q_idx,
    output tc_pkg::tc_way_t  victim
);
    logic [SETS-1:0] lru_q;

    // Point each touched set at the way that was not touched.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lru_q <= '0;
        else
            for (int s = 0; s < SETS; s++) begin
                if (wr_en && wr_idx == IDX_W'(s))
                    lru_q[s] <= ~wr_way;
                else if (hit_en && hit_idx == IDX_W'(s))
                    lru_q[s] <= ~hit_way;
            end
    end

    assign victim = lru_q[q_idx];

    AST_LRU_AWAY_FROM_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> lru_q[$past(wr_idx)] != $past(wr_way)); // R9
endmodule

// File: rtl/trace_cache_array.sv
`timescale 1ns/1ps
// Two-way set-associative trace array with one lookup port and one fill port.
// Lookup result is registered: it appears one cycle after the request and
// reflects the array before any fill made in the request cycle.
// Assumes MAX_BR >= 2 and SETS a power of two.
module trace_cache_array #(
    parameter int  PC_W      = 32,
    parameter int  INSTR_W   = 32,
    parameter int  MAX_INSTR = 24,
    parameter int  MAX_BR    = 3,
    parameter int  SETS      = 8,
    localparam int IDX_W     = $clog2(SETS),
    localparam int TAG_W     = PC_W - IDX_W - 2,
    localparam int NBR_W     = $clog2(MAX_BR + 1),
    localparam int FLAG_W    = MAX_BR - 1,
    localparam int CNT_W     = $clog2(MAX_INSTR + 1),
    localparam int DATA_W    = MAX_INSTR * INSTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic [MAX_BR-1:0] lk_pred,
    input  logic              fill_en,
    input  logic [PC_W-1:0]   fill_pc,
    input  logic [NBR_W-1:0]  fill_nbr,
    input  logic [FLAG_W-1:0] fill_dirs,
    input  logic [CNT_W-1:0]  fill_cnt,
    input  logic [PC_W-1:0]   fill_target,
    input  logic [PC_W-1:0]   fill_fallthru,
    input  logic [DATA_W-1:0] fill_instrs,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [CNT_W-1:0]  rsp_cnt,
    output logic [PC_W-1:0]   rsp_next_pc,
    output logic [DATA_W-1:0] rsp_instrs
);
    import tc_pkg::*;

    logic [IDX_W-1:0] lk_idx, wr_idx;
    logic [TAG_W-1:0] lk_tag, wr_tag;
    logic             unused_lo;

    assign lk_idx    = lk_pc[IDX_W+1:2];
    assign lk_tag    = lk_pc[PC_W-1:IDX_W+2];
    assign wr_idx    = fill_pc[IDX_W+1:2];
    assign wr_tag    = fill_pc[PC_W-1:IDX_W+2];
    assign unused_lo = ^{lk_pc[1:0], fill_pc[1:0]};

    logic              rd_vld   [TC_WAYS];
    logic [TAG_W-1:0]  rd_tag   [TC_WAYS];
    logic [NBR_W-1:0]  rd_nbr   [TC_WAYS];
    logic [FLAG_W-1:0] rd_flags [TC_WAYS];
    logic [CNT_W-1:0]  rd_cnt   [TC_WAYS];
    logic [PC_W-1:0]   rd_tgt   [TC_WAYS];
    logic [PC_W-1:0]   rd_fall  [TC_WAYS];
    logic [DATA_W-1:0] rd_data  [TC_WAYS];
    logic              wq_vld   [TC_WAYS];
    logic [TAG_W-1:0]  wq_tag   [TC_WAYS];
    logic [NBR_W-1:0]  wq_nbr   [TC_WAYS];
    logic [FLAG_W-1:0] wq_flags [TC_WAYS];
    logic [TC_WAYS-1:0] way_hit, way_same;
    tc_way_t           wr_way, hit_way, victim;

    for (genvar w = 0; w < TC_WAYS; w++) begin : g_way
        tc_way_store #(
            .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .NBR_W(NBR_W),
            .FLAG_W(FLAG_W), .CNT_W(CNT_W), .PC_W(PC_W), .DATA_W(DATA_W)
        ) u_store (
            .clk(clk), .rst_n(rst_n),
            .wr_en(fill_en && wr_way == tc_way_t'(w)),
            .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_nbr(fill_nbr),
            .wr_flags(fill_dirs), .wr_cnt(fill_cnt), .wr_tgt(fill_target),
            .wr_fall(fill_fallthru), .wr_data(fill_instrs),
            .rd_idx(lk_idx),
            .rd_vld(rd_vld[w]), .rd_tag(rd_tag[w]), .rd_nbr(rd_nbr[w]),
            .rd_flags(rd_flags[w]), .rd_cnt(rd_cnt[w]), .rd_tgt(rd_tgt[w]),
            .rd_fall(rd_fall[w]), .rd_data(rd_data[w]),
            .wq_vld(wq_vld[w]), .wq_tag(wq_tag[w]), .wq_nbr(wq_nbr[w]),
            .wq_flags(wq_flags[w])
        );

        tc_match #(.TAG_W(TAG_W), .NBR_W(NBR_W), .FLAG_W(FLAG_W)) u_lk_match (
            .e_vld(rd_vld[w]), .e_tag(rd_tag[w]), .e_nbr(rd_nbr[w]),
            .e_flags(rd_flags[w]), .q_tag(lk_tag), .q_nbr('0),
            .q_flags(lk_pred[FLAG_W-1:0]), .chk_nbr(1'b0), .match(way_hit[w])
        );

        tc_match #(.TAG_W(TAG_W), .NBR_W(NBR_W), .FLAG_W(FLAG_W)) u_wr_match (
            .e_vld(wq_vld[w]), .e_tag(wq_tag[w]), .e_nbr(wq_nbr[w]),
            .e_flags(wq_flags[w]), .q_tag(wr_tag), .q_nbr(fill_nbr),
            .q_flags(fill_dirs), .chk_nbr(1'b1), .match(way_same[w])
        );
    end

    tc_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .hit_en(lk_valid && (|way_hit)), .hit_idx(lk_idx), .hit_way(hit_way),
        .wr_en(fill_en), .wr_idx(wr_idx), .wr_way(wr_way),
        .q_idx(wr_idx), .victim(victim)
    );

    // Fill placement: same path first, then lowest empty way, then LRU victim.
    always_comb begin
        if (way_same[0])      wr_way = 1'b0;
        else if (way_same[1]) wr_way = 1'b1;
        else if (!wq_vld[0])  wr_way = 1'b0;
        else if (!wq_vld[1])  wr_way = 1'b1;
        else                  wr_way = victim;
    end

    // Hit way (way 0 wins a tie) and the direction of the trace's last branch.
    logic [NBR_W-1:0] sel_nbr;
    logic             last_dir;
    logic [PC_W-1:0]  sel_next;
    always_comb begin
        hit_way  = way_hit[0] ? 1'b0 : 1'b1;
        sel_nbr  = rd_nbr[hit_way];
        last_dir = 1'b0;
        for (int i = 1; i <= MAX_BR; i++)
            if (sel_nbr == NBR_W'(i))
                last_dir = lk_pred[i-1];
        sel_next = (sel_nbr != '0 && last_dir) ? rd_tgt[hit_way] : rd_fall[hit_way];
    end

    // Register the lookup response; misses return zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_cnt     <= '0;
            rsp_next_pc <= '0;
            rsp_instrs  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && (|way_hit);
            if (lk_valid && (|way_hit)) begin
                rsp_cnt     <= rd_cnt[hit_way];
                rsp_next_pc <= sel_next;
                rsp_instrs  <= rd_data[hit_way];
            end else begin
                rsp_cnt     <= '0;
                rsp_next_pc <= '0;
                rsp_instrs  <= '0;
            end
        end
    end

    AST_RSP_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid); // R2
    AST_HIT_IMPLIES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid); // R2
    AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_cnt == '0 && rsp_next_pc == '0 && rsp_instrs == '0)); // R6
endmodule

// File: tb/trace_cache_array_bench.sv
`timescale 1ns/1ps
module trace_cache_array_bench;
    localparam int SETS = 8, WAYS = 2, DW = 768, TW = 27;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_valid = 0; logic [31:0] lk_pc = 0; logic [2:0] lk_pred = 0;
    logic fill_en = 0; logic [31:0] fill_pc = 0; logic [1:0] fill_nbr = 0, fill_dirs = 0;
    logic [4:0] fill_cnt = 0; logic [31:0] fill_target = 0, fill_fallthru = 0;
    logic [DW-1:0] fill_instrs = 0;
    logic rsp_valid, rsp_hit; logic [4:0] rsp_cnt; logic [31:0] rsp_next_pc;
    logic [DW-1:0] rsp_instrs;

    trace_cache_array u_trace_cache_array (.*);

    always #2 clk = ~clk;

    // Reference model of every entry and every recency bit.
    bit          mv [SETS][WAYS];
    logic [TW-1:0] mt [SETS][WAYS];
    logic [1:0]  mn [SETS][WAYS], mf [SETS][WAYS];
    logic [4:0]  mc [SETS][WAYS];
    logic [31:0] mtg[SETS][WAYS], mfa[SETS][WAYS];
    logic [DW-1:0] md [SETS][WAYS];
    bit          mlru [SETS];

    int checks = 0, failures = 0;
    bit finished = 0;

    function automatic logic [31:0] mkpc(input int tag, input int set, input int lo);
        return {TW'(tag), 3'(set), 2'(lo)};
    endfunction

    function automatic logic [DW-1:0] mkdata(input int seed);
        logic [DW-1:0] d;
        for (int k = 0; k < 24; k++) d[k*32 +: 32] = 32'(seed) * 32'h9E3779B1 + 32'(k);
        return d;
    endfunction

    function automatic bit dirs_ok(input logic [1:0] nbr, input logic [1:0] st, input logic [1:0] q);
        for (int i = 0; i < 2; i++)
            if (i + 1 < int'(nbr) && st[i] != q[i]) return 0;
        return 1;
    endfunction

    task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: inputs already driven at a negedge; predict, clock, compare.
    task automatic step(input string req);
        int li, wi, hw, ww;
        bit eh;
        logic [4:0] ec; logic [31:0] en; logic [DW-1:0] ed;
        li = int'(lk_pc[4:2]); wi = int'(fill_pc[4:2]);
        eh = 0; hw = 0; ec = 0; en = 0; ed = 0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (mv[li][w] && mt[li][w] == lk_pc[31:5] && dirs_ok(mn[li][w], mf[li][w], lk_pred[1:0])) begin
                eh = 1; hw = w;
            end
        if (eh) begin
            ec = mc[li][hw]; ed = md[li][hw];
            en = (mn[li][hw] != 0 && lk_pred[mn[li][hw] - 1]) ? mtg[li][hw] : mfa[li][hw];
        end
        ww = -1;
        for (int w = WAYS - 1; w >= 0; w--)
            if (mv[wi][w] && mt[wi][w] == fill_pc[31:5] && mn[wi][w] == fill_nbr &&
                dirs_ok(mn[wi][w], mf[wi][w], fill_dirs)) ww = w;
        if (ww < 0) begin
            if (!mv[wi][0]) ww = 0; else if (!mv[wi][1]) ww = 1; else ww = int'(mlru[wi]);
        end
        @(posedge clk);
        if (lk_valid && eh) mlru[li] = (hw == 0);
        if (fill_en) begin
            mv[wi][ww] = 1; mt[wi][ww] = fill_pc[31:5]; mn[wi][ww] = fill_nbr;
            mf[wi][ww] = fill_dirs; mc[wi][ww] = fill_cnt; mtg[wi][ww] = fill_target;
            mfa[wi][ww] = fill_fallthru; md[wi][ww] = fill_instrs;
            mlru[wi] = (ww == 0);
        end
        @(negedge clk);
        chk(req, "rsp_valid", DW'(rsp_valid), DW'(lk_valid));
        if (lk_valid) begin
            chk(req, "rsp_hit", DW'(rsp_hit), DW'(eh));
            chk(req, "rsp_cnt", DW'(rsp_cnt), DW'(ec));
            chk(req, "rsp_next_pc", DW'(rsp_next_pc), DW'(en));
            chk(req, "rsp_instrs", rsp_instrs, ed);
        end
        lk_valid = 0; fill_en = 0;
    endtask

    task automatic set_fill(input logic [31:0] pc, input int nbr, input int dirs, input int cnt, input int seed);
        fill_en = 1; fill_pc = pc; fill_nbr = 2'(nbr); fill_dirs = 2'(dirs);
        fill_cnt = 5'(cnt); fill_target = pc + 32'h100 + 32'(seed);
        fill_fallthru = pc + 32'h60 + 32'(seed); fill_instrs = mkdata(seed);
    endtask

    task automatic set_look(input logic [31:0] pc, input int pred);
        lk_valid = 1; lk_pc = pc; lk_pred = 3'(pred);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: idle after reset, then misses everywhere
        step("R1");
        for (int s = 0; s < SETS; s++) begin set_look(mkpc(1, s, 0), 7); step("R1"); end
        // R3 R6: basic hit, low bits ignored, other tag / other set miss
        set_fill(mkpc(5, 2, 0), 1, 0, 7, 11); step("R6");
        set_look(mkpc(5, 2, 0), 0); step("R6");
        set_look(mkpc(5, 2, 3), 1); step("R3");
        set_look(mkpc(6, 2, 0), 0); step("R3");
        set_look(mkpc(5, 3, 0), 0); step("R3");
        // R4 R5: three branches, dirs = b10
        set_fill(mkpc(9, 4, 0), 3, 2, 24, 21); step("R4");
        set_look(mkpc(9, 4, 0), 3'b011); step("R4");
        set_look(mkpc(9, 4, 0), 3'b010); step("R5");
        set_look(mkpc(9, 4, 0), 3'b110); step("R5");
        set_fill(mkpc(9, 5, 0), 0, 3, 3, 22); step("R5");
        set_look(mkpc(9, 5, 0), 3'b111); step("R5");
        // R7: two paths from the same start
        set_fill(mkpc(3, 6, 0), 2, 0, 10, 31); step("R7");
        set_fill(mkpc(3, 6, 0), 2, 1, 12, 32); step("R7");
        set_look(mkpc(3, 6, 0), 3'b000); step("R7");
        set_look(mkpc(3, 6, 0), 3'b001); step("R7");
        // R8: same path rewritten in place
        set_fill(mkpc(3, 6, 0), 2, 1, 14, 33); step("R8");
        set_look(mkpc(3, 6, 0), 3'b000); step("R8");
        set_look(mkpc(3, 6, 0), 3'b101); step("R8");
        // R9: hit way 0 path, then a third path evicts the other way
        set_look(mkpc(3, 6, 0), 3'b000); step("R9");
        set_fill(mkpc(4, 6, 0), 1, 0, 5, 34); step("R9");
        set_look(mkpc(3, 6, 0), 3'b001); step("R9");
        set_look(mkpc(3, 6, 0), 3'b000); step("R9");
        set_look(mkpc(4, 6, 0), 3'b000); step("R9");
        // R11: both ways hit, way 0 answers
        set_fill(mkpc(7, 7, 0), 1, 0, 4, 41); step("R11");
        set_fill(mkpc(7, 7, 0), 2, 1, 8, 42); step("R11");
        set_look(mkpc(7, 7, 0), 3'b001); step("R11");
        // R10: lookup in the fill cycle sees old contents
        set_fill(mkpc(2, 1, 0), 1, 0, 9, 51); set_look(mkpc(2, 1, 0), 0); step("R10");
        set_look(mkpc(2, 1, 0), 0); step("R10");
        // Random phase: small tag pool keeps sets contended
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 10 < 3)
                set_fill(mkpc(1 + $urandom % 3, $urandom % SETS, $urandom % 4), $urandom % 4,
                         $urandom % 4, 1 + $urandom % 24, int'($urandom % 1000));
            if ($urandom % 10 < 7)
                set_look(mkpc(1 + $urandom % 3, $urandom % SETS, $urandom % 4), $urandom % 8);
            step("R9");
        end
        summary();
    end
endmodule